// File: doc/BRIEF.md
# Hot-Plug Slot Register Controller

This block holds the slot capability, slot control and slot status registers of a hot-plug capable downstream or root port. Software reaches the registers through a simple word-wide write/read port with byte enables. Each write to the control register is taken as one command that completes at once. Slot-side inputs report a hot-add, an attention button press, a power fault and a link state change. Each of these sets sticky event bits that software clears by writing ones.

The block reduces event status, event enables and a global hot-plug interrupt enable to one notify condition. It signals software only when that condition changes. With message interrupts enabled it sends a one-cycle request carrying a 5-bit vector taken from a software-written message-number register. Otherwise a legacy interrupt line follows the condition level. The block also keeps the electromechanical interlock state, the power controller bit and the two indicator fields. Writing the power controller off together with the power indicator off to an occupied slot detaches the device.

Top module: `hp_slot_ctl`

## Requirements
- R1: After reset the message-number register (address 0) reads 0 and control (address 2) reads 0x00C0, which is the attention indicator field [7:6] at 11 (off) with every other bit clear. Status (address 3) reads 0 except presence (bit 5), which takes the value of `slotOccupied` during reset. No event is raised and both interrupt outputs are low.
- R2: Control writes honour byte enables: byte 0 holds bits [7:0] and byte 1 holds bits [15:8]. Control fields: [4:0] per-event enables, [5] hot-plug interrupt enable, [7:6] attention indicator, [9:8] power indicator, [10] power controller (1 = off), [11] interlock command. Address 1 reads {slot number[7:0], 3'b0, supported-event mask[4:0]} (default 0x050D) and ignores writes. Message number is [4:0] of address 0, written with byte 0.
- R3: Status event bits [0] button, [1] power fault, [2] presence changed, [3] command done and [4] link changed are write-1-to-clear through byte 0. A write with byte 0 disabled clears nothing.
- R4: Every control write with at least one byte enabled sets command done (status bit 3) on the same clock edge. A write with no byte enabled is not a command.
- R5: The interlock command bit (control bit 11) always reads 0. Each control write with it at 1 toggles the interlock status bit (status bit 6).
- R6: A hot-add pulse sets presence (bit 5) and raises presence changed and button together. Button, power-fault and link-change pulses set bits 0, 1 and 4.
- R7: A control write that leaves power controller = 1 and power indicator = 11 while presence is set clears presence and sets presence changed. With any other indicator value presence is unchanged.
- R8: The notify condition is: hot-plug interrupt enable AND any bit of (status[4:0] AND enables[4:0] AND supported mask). The default supported mask is 01101, meaning button, presence changed and command done.
- R9: With message interrupts enabled, `msgReq` pulses for one cycle, carrying the message number on `msgVector`, one cycle after each change of the notify condition. It pulses on both the rise and the fall. Setting an event bit that is already set gives no pulse.
- R10: With message interrupts disabled, `intxLevel` follows the notify condition one cycle late and drops once no enabled event remains. With them enabled it stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| slotOccupied | input | 1 | Device present at reset (sampled during reset) |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register select for write and read |
| regWrData | input | 16 | Write data |
| regByteEn | input | 2 | Write byte enables |
| regRdData | output | 16 | Read data of the selected register |
| btnPress | input | 1 | Attention button pulse |
| pwrFault | input | 1 | Power fault pulse |
| linkChange | input | 1 | Link state change pulse |
| hotAdd | input | 1 | Hot-add pulse |
| msgIntEn | input | 1 | Message interrupts enabled |
| intxLevel | output | 1 | Legacy level interrupt |
| msgReq | output | 1 | One-cycle message interrupt request |
| msgVector | output | 5 | Vector sent with the request |

## Verification
A wrong status or control bit can be read on `regRdData` immediately after the clock edge that caused it. A stale or wrong notify condition shows one cycle later: `intxLevel` stuck at the wrong level, a missing or doubled `msgReq` pulse, or a pulse when an already-set event is raised again. The bench sweeps every event-enable pattern against every event source, and all 32 vector values, so a wrong term in the notify reduction or the vector path appears within two cycles of the stimulus that exposes it.

// File: rtl/hpslot_pkg.sv
package hpslot_pkg;
  localparam int REG_W = 16;
  localparam int BE_W  = REG_W / 8;
  localparam int EVT_N = 5;

  localparam int EV_BUTTON  = 0;
  localparam int EV_PFAULT  = 1;
  localparam int EV_PDCHG   = 2;
  localparam int EV_CMDDONE = 3;
  localparam int EV_LINK    = 4;
  localparam int CTRL_LOCK_BIT = 11;

  typedef enum logic [1:0] {
    ADDR_MSGNUM  = 2'd0,
    ADDR_SLOTCAP = 2'd1,
    ADDR_CTRL    = 2'd2,
    ADDR_STAT    = 2'd3
  } regSel_e;

  localparam logic [1:0] IND_ON    = 2'b01;
  localparam logic [1:0] IND_BLINK = 2'b10;
  localparam logic [1:0] IND_OFF   = 2'b11;

  typedef struct packed {
    logic [3:0]       rsvd;
    logic             lockCmd;
    logic             pwrOff;
    logic [1:0]       pwrInd;
    logic [1:0]       attnInd;
    logic             hpIntEn;
    logic [EVT_N-1:0] evtEn;
  } slotCtrl_t;

  typedef struct packed {
    logic             wrMsgNum;
    logic [4:0]       msgNum;
    logic             wrCtrl;
    logic [REG_W-1:0] ctrlMask;
    logic [REG_W-1:0] ctrlData;
    logic [EVT_N-1:0] evtClr;
    logic [EVT_N-1:0] evtSet;
    logic             hotAdd;
    logic             lockToggle;
  } slotStb_t;
endpackage

// File: rtl/hpslot_decode.sv
module hpslot_decode
  import hpslot_pkg::*;
(
  input  logic                 regWrEn,
  input  logic [1:0]           regAddr,
  input  logic [REG_W-1:0]     regWrData,
  input  logic [BE_W-1:0]      regByteEn,
  input  logic                 btnPress,
  input  logic                 pwrFault,
  input  logic                 linkChange,
  input  logic                 hotAdd,
  output slotStb_t             stb
);
  logic [REG_W-1:0] byteMask;
  logic             wrHit;

  always_comb begin
    for (int b = 0; b < BE_W; b++) begin
      byteMask[b*8 +: 8] = {8{regByteEn[b]}};
    end
  end

  assign wrHit = regWrEn && (|regByteEn);

  always_comb begin
    stb          = '0;
    stb.wrMsgNum = wrHit && (regAddr == ADDR_MSGNUM) && regByteEn[0];
    stb.msgNum   = regWrData[4:0];
    stb.wrCtrl   = wrHit && (regAddr == ADDR_CTRL);
    stb.ctrlMask = byteMask;
    stb.ctrlData = regWrData;
    stb.evtClr   = (wrHit && (regAddr == ADDR_STAT) && regByteEn[0]) ?
                   regWrData[EVT_N-1:0] : '0;
    stb.evtSet[EV_BUTTON]  = btnPress || hotAdd;
    stb.evtSet[EV_PFAULT]  = pwrFault;
    stb.evtSet[EV_PDCHG]   = hotAdd;
    stb.evtSet[EV_CMDDONE] = stb.wrCtrl;
    stb.evtSet[EV_LINK]    = linkChange;
    stb.hotAdd     = hotAdd;
    stb.lockToggle = stb.wrCtrl && byteMask[CTRL_LOCK_BIT] && regWrData[CTRL_LOCK_BIT];
  end
endmodule

// File: rtl/hpslot_regs.sv
module hpslot_regs
  import hpslot_pkg::*;
#(
  parameter int               SLOT_NUM  = 5,
  parameter logic [EVT_N-1:0] SUPPORTED = 5'b01101
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             slotOccupied,
  input  slotStb_t         stb,
  input  logic [1:0]       regAddr,
  output logic [REG_W-1:0] regRdData,
  output logic             hpIntEn,
  output logic [EVT_N-1:0] evtEn,
  output logic [EVT_N-1:0] evtQ,
  output logic [4:0]       msgNumQ
);
  localparam logic [7:0] SLOT_ID = 8'(SLOT_NUM);
  localparam logic [REG_W-1:0] CAP_WORD = {SLOT_ID, 3'b000, SUPPORTED};

  slotCtrl_t ctrlQ, ctrlMerged, ctrlNext, ctrlReset;
  logic      presentQ, lockQ, detach;

  always_comb begin
    ctrlReset         = '0;
    ctrlReset.attnInd = IND_OFF;
  end

  assign ctrlMerged = slotCtrl_t'((ctrlQ & ~stb.ctrlMask) | (stb.ctrlData & stb.ctrlMask));

  always_comb begin
    ctrlNext         = ctrlMerged;
    ctrlNext.lockCmd = 1'b0;
    ctrlNext.rsvd    = '0;
  end

  assign detach = stb.wrCtrl && presentQ && ctrlMerged.pwrOff &&
                  (ctrlMerged.pwrInd == IND_OFF);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlQ    <= ctrlReset;
      evtQ     <= '0;
      presentQ <= slotOccupied;
      lockQ    <= 1'b0;
      msgNumQ  <= '0;
    end else begin
      if (stb.wrCtrl) ctrlQ <= ctrlNext;
      evtQ <= (evtQ & ~stb.evtClr) | stb.evtSet | (EVT_N'(detach) << EV_PDCHG);
      if (stb.hotAdd)  presentQ <= 1'b1;
      else if (detach) presentQ <= 1'b0;
      if (stb.lockToggle) lockQ <= ~lockQ;
      if (stb.wrMsgNum)   msgNumQ <= stb.msgNum;
    end
  end

  assign hpIntEn = ctrlQ.hpIntEn;
  assign evtEn   = ctrlQ.evtEn;

  always_comb begin
    regRdData = '0;
    case (regAddr)
      ADDR_MSGNUM:  regRdData = {11'd0, msgNumQ};
      ADDR_SLOTCAP: regRdData = CAP_WORD;
      ADDR_CTRL:    regRdData = ctrlQ;
      default:      regRdData = {9'd0, lockQ, presentQ, evtQ};
    endcase
  end

  AST_CMD_DONE: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrCtrl |=> evtQ[EV_CMDDONE]); // R4
  AST_LOCK_TOGGLE: assert property (@(posedge clk) disable iff (!rstN)
    stb.lockToggle |=> (lockQ != $past(lockQ))); // R5
  AST_BTN_W1C: assert property (@(posedge clk) disable iff (!rstN)
    (stb.evtClr[EV_BUTTON] && !stb.evtSet[EV_BUTTON]) |=> !evtQ[EV_BUTTON]); // R3
  AST_HOT_ADD: assert property (@(posedge clk) disable iff (!rstN)
    stb.hotAdd |=> (presentQ && evtQ[EV_PDCHG] && evtQ[EV_BUTTON])); // R6
  AST_DETACH_FLAGS: assert property (@(posedge clk) disable iff (!rstN)
    $fell(presentQ) |-> evtQ[EV_PDCHG]); // R7
endmodule

// File: rtl/hpslot_irq.sv
module hpslot_irq
  import hpslot_pkg::*;
#(
  parameter logic [EVT_N-1:0] SUPPORTED = 5'b01101
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             hpIntEn,
  input  logic [EVT_N-1:0] evtEn,
  input  logic [EVT_N-1:0] evtQ,
  input  logic [4:0]       msgNumQ,
  input  logic             msgIntEn,
  output logic             intxLevel,
  output logic             msgReq,
  output logic [4:0]       msgVector
);
  logic notifyNow, notifyQ;

  assign notifyNow = hpIntEn && (|(evtQ & evtEn & SUPPORTED));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      notifyQ   <= 1'b0;
      msgReq    <= 1'b0;
      intxLevel <= 1'b0;
    end else begin
      notifyQ   <= notifyNow;
      msgReq    <= msgIntEn && (notifyNow != notifyQ);
      intxLevel <= notifyNow && !msgIntEn;
    end
  end

  assign msgVector = msgNumQ;

  AST_MSG_ON_CHANGE: assert property (@(posedge clk) disable iff (!rstN)
    msgReq |-> (notifyQ != $past(notifyQ))); // R9
  AST_INTX_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    msgIntEn |=> !intxLevel); // R10
  AST_NO_UNSUPPORTED: assert property (@(posedge clk) disable iff (!rstN)
    !(|(evtQ & SUPPORTED)) |=> !intxLevel); // R8
endmodule

// File: rtl/hp_slot_ctl.sv
module hp_slot_ctl
  import hpslot_pkg::*;
#(
  parameter int               SLOT_NUM  = 5,
  parameter logic [EVT_N-1:0] SUPPORTED = 5'b01101
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        slotOccupied,
  input  logic        regWrEn,
  input  logic [1:0]  regAddr,
  input  logic [15:0] regWrData,
  input  logic [1:0]  regByteEn,
  output logic [15:0] regRdData,
  input  logic        btnPress,
  input  logic        pwrFault,
  input  logic        linkChange,
  input  logic        hotAdd,
  input  logic        msgIntEn,
  output logic        intxLevel,
  output logic        msgReq,
  output logic [4:0]  msgVector
);
  slotStb_t         stb;
  logic             hpIntEn;
  logic [EVT_N-1:0] evtEn, evtQ;
  logic [4:0]       msgNumQ;

  hpslot_decode u_decode (
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .regByteEn(regByteEn), .btnPress(btnPress), .pwrFault(pwrFault),
    .linkChange(linkChange), .hotAdd(hotAdd), .stb(stb)
  );

  hpslot_regs #(.SLOT_NUM(SLOT_NUM), .SUPPORTED(SUPPORTED)) u_regs (
    .clk(clk), .rstN(rstN), .slotOccupied(slotOccupied), .stb(stb),
    .regAddr(regAddr), .regRdData(regRdData), .hpIntEn(hpIntEn),
    .evtEn(evtEn), .evtQ(evtQ), .msgNumQ(msgNumQ)
  );

  hpslot_irq #(.SUPPORTED(SUPPORTED)) u_irq (
    .clk(clk), .rstN(rstN), .hpIntEn(hpIntEn), .evtEn(evtEn), .evtQ(evtQ),
    .msgNumQ(msgNumQ), .msgIntEn(msgIntEn), .intxLevel(intxLevel),
    .msgReq(msgReq), .msgVector(msgVector)
  );
endmodule

// File: tb/hp_slot_ctl_bench.sv
`timescale 1ns/1ps
module hp_slot_ctl_bench;
  localparam logic [4:0] SUP = 5'b01101;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        slotOccupied = 1'b1;
  logic        regWrEn = 1'b0;
  logic [1:0]  regAddr = 2'd0;
  logic [15:0] regWrData = '0;
  logic [1:0]  regByteEn = '0;
  logic [15:0] regRdData;
  logic        btnPress = 1'b0, pwrFault = 1'b0, linkChange = 1'b0, hotAdd = 1'b0;
  logic        msgIntEn = 1'b0;
  logic        intxLevel, msgReq;
  logic [4:0]  msgVector;

  int vectors = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  hp_slot_ctl u_hp_slot_ctl (
    .clk(clk), .rstN(rstN), .slotOccupied(slotOccupied), .regWrEn(regWrEn),
    .regAddr(regAddr), .regWrData(regWrData), .regByteEn(regByteEn),
    .regRdData(regRdData), .btnPress(btnPress), .pwrFault(pwrFault),
    .linkChange(linkChange), .hotAdd(hotAdd), .msgIntEn(msgIntEn),
    .intxLevel(intxLevel), .msgReq(msgReq), .msgVector(msgVector)
  );

  task automatic check(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wrReg(input logic [1:0] a, input logic [15:0] d, input logic [1:0] be);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d; regByteEn = be;
    @(negedge clk);
    regWrEn = 1'b0; regByteEn = '0;
  endtask

  task automatic rdReg(input logic [1:0] a, output int v);
    regAddr = a;
    #1;
    v = int'(regRdData);
  endtask

  task automatic pulseEvt(input int which);
    @(negedge clk);
    case (which)
      0: btnPress = 1'b1;
      1: pwrFault = 1'b1;
      2: hotAdd = 1'b1;
      default: linkChange = 1'b1;
    endcase
    @(negedge clk);
    btnPress = 1'b0; pwrFault = 1'b0; hotAdd = 1'b0; linkChange = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    int v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    rdReg(0, v); check("R1 msgnum", v, 0);
    rdReg(1, v); check("R1 cap", v, 16'h050D);
    rdReg(2, v); check("R1 ctrl", v, 16'h00C0);
    rdReg(3, v); check("R1 status", v, 16'h0020);
    check("R1 intx", int'(intxLevel), 0);
    check("R1 msgReq", int'(msgReq), 0);

    // R2 capability is read-only, byte enables on control
    wrReg(1, 16'hFFFF, 2'b11);
    rdReg(1, v); check("R2 cap ro", v, 16'h050D);
    rdReg(3, v); check("R4 cap write no cmd", v, 16'h0020);
    wrReg(2, 16'h0A2A, 2'b01);
    rdReg(2, v); check("R2 ctrl low byte", v, 16'h002A);
    rdReg(3, v); check("R4 cmd done", v, 16'h0028);
    @(negedge clk);
    check("R8 intx cmd done", int'(intxLevel), 1);
    wrReg(2, 16'h0500, 2'b10);
    rdReg(2, v); check("R2 ctrl high byte", v, 16'h052A);
    rdReg(3, v); check("R7 no detach when ind on", v, 16'h0028);

    // R3 clear, R10 legacy drop
    wrReg(3, 16'h0008, 2'b01);
    rdReg(3, v); check("R3 w1c", v, 16'h0020);
    @(negedge clk);
    check("R10 intx drops", int'(intxLevel), 0);
    wrReg(2, 16'hFFFF, 2'b00);
    rdReg(3, v); check("R4 no enable no cmd", v, 16'h0020);
    rdReg(2, v); check("R2 no enable no change", v, 16'h052A);

    // R5 interlock
    wrReg(2, 16'h0D2A, 2'b11);
    rdReg(2, v); check("R5 lock bit reads 0", v, 16'h052A);
    rdReg(3, v); check("R5 lock set", v, 16'h0068);
    wrReg(2, 16'h0D2A, 2'b11);
    rdReg(3, v); check("R5 lock toggled back", v, 16'h0028);

    // R7 detach
    wrReg(2, 16'h072A, 2'b11);
    rdReg(3, v); check("R7 detach", v, 16'h000C);
    wrReg(3, 16'h001F, 2'b01);
    rdReg(3, v); check("R3 clear all", v, 16'h0000);

    // R6 slot inputs
    pulseEvt(2);
    rdReg(3, v); check("R6 hot add", v, 16'h0025);
    pulseEvt(1);
    rdReg(3, v); check("R6 power fault", v, 16'h0027);
    pulseEvt(3);
    rdReg(3, v); check("R6 link change", v, 16'h0037);
    @(negedge clk);
    check("R8 unsupported pf no intx", int'(intxLevel), 0);
    wrReg(3, 16'h0011, 2'b01);
    rdReg(3, v); check("R3 partial clear", v, 16'h0026);
    wrReg(3, 16'h00FF, 2'b10);
    rdReg(3, v); check("R3 high byte no clear", v, 16'h0026);
    wrReg(3, 16'h001F, 2'b01);

    // R8/R10 sweep: all enable patterns x all event sources
    for (int en = 0; en < 32; en++) begin
      for (int src = 0; src < 5; src++) begin
        logic [4:0] evMask;
        int expInt;
        case (src)
          0: evMask = 5'b00001;
          1: evMask = 5'b00010;
          2: evMask = 5'b00101;
          3: evMask = 5'b01000;
          default: evMask = 5'b10000;
        endcase
        expInt = int'(|(evMask & 5'(en) & SUP));
        wrReg(2, 16'h0020 | 16'(en), 2'b11);
        wrReg(3, 16'h001F, 2'b01);
        @(negedge clk);
        check("R10 sweep idle", int'(intxLevel), 0);
        case (src)
          0: pulseEvt(0);
          1: pulseEvt(1);
          2: pulseEvt(2);
          3: wrReg(2, 16'h0020 | 16'(en), 2'b11);
          default: pulseEvt(3);
        endcase
        rdReg(3, v); check("R6 sweep status", v & 16'h1F, int'(evMask));
        @(negedge clk);
        check("R8 sweep intx", int'(intxLevel), expInt);
        wrReg(3, 16'h001F, 2'b01);
        @(negedge clk);
        check("R10 sweep cleared", int'(intxLevel), 0);
      end
    end

    // R8 global enable off
    wrReg(2, 16'h001F, 2'b11);
    wrReg(3, 16'h001F, 2'b01);
    pulseEvt(0);
    @(negedge clk);
    check("R8 hp int disabled", int'(intxLevel), 0);

    // R9 message sweep over all vectors
    msgIntEn = 1'b1;
    wrReg(2, 16'h0021, 2'b11);
    wrReg(3, 16'h001F, 2'b01);
    @(negedge clk);
    @(negedge clk);
    for (int vec = 0; vec < 32; vec++) begin
      wrReg(0, 16'(vec), 2'b01);
      rdReg(0, v); check("R2 msgnum", v, vec);
      pulseEvt(0);
      @(negedge clk);
      check("R9 pulse on rise", int'(msgReq), 1);
      check("R9 vector", int'(msgVector), vec);
      check("R10 intx quiet", int'(intxLevel), 0);
      @(negedge clk);
      check("R9 one cycle", int'(msgReq), 0);
      pulseEvt(0);
      @(negedge clk);
      check("R9 already set", int'(msgReq), 0);
      wrReg(3, 16'h0001, 2'b01);
      @(negedge clk);
      check("R9 pulse on fall", int'(msgReq), 1);
      @(negedge clk);
      check("R9 fall one cycle", int'(msgReq), 0);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule